// File: doc/BRIEF.md
# Double-Buffered Low-Resolution Frame Display

This block scans a small source image out to a triple 8-bit video DAC at standard 640x480, 60 Hz raster timing. The image lives in one of two on-chip frame stores. While one store is scanned out, the host fills the other with a complete frame in a single burst of word writes. After the last word, the host pulses a frame-complete input.

Each source pixel is enlarged by repeating it along both axes. With the default 64x48 source and a factor of ten, the image exactly fills the visible area. When the last visible line ends and vertical blanking begins, the block checks whether the host has finished a new frame. If it has, the two stores change roles and a one-cycle interrupt asks the host for the next frame. If it has not, the same store is shown again and no interrupt is raised.

Top module: `vga_dbuf_ctrl`

## Requirements
- R1: While reset is high, and for the first two cycles after reset is released, both syncs are high, all three colour outputs are zero and the interrupt is low. After reset, store 0 is the one displayed.
- R2: The raster position advances once per clock. A line is VIS_W+H_FRONT+H_SYNC+H_BACK clocks long, and the first VIS_W positions of the line are visible. `hsync_n_o` is low for exactly the H_SYNC positions that begin VIS_W+H_FRONT positions into the line.
- R3: A frame is VIS_H+V_FRONT+V_SYNC+V_BACK lines long, and the first VIS_H lines are visible. `vsync_n_o` is low for the whole of the V_SYNC lines that begin VIS_H+V_FRONT lines into the frame.
- R4: The colour outputs are zero at every position that is outside the visible columns or outside the visible lines.
- R5: At visible position (x, y), the outputs carry the word at store address (y/REP)*SRC_W + x/REP, with red from bits 23:16, green from bits 15:8 and blue from bits 7:0. Bits 31:24 have no effect.
- R6: All outputs lag the raster position by two clocks.
- R7: A host write goes to the store that is not displayed, and it leaves the displayed image unchanged.
- R8: The stores swap only on the clock that ends the last visible line, and only if a frame-complete pulse has arrived since the previous swap. The swap consumes that pulse. A pulse on the same clock as the swap is kept for the next boundary.
- R9: `irq_o` is high for exactly one clock, on the clock after each swap, and at no other time.
- R10: If no new frame is ready at the boundary, the previous image is shown again in the next frame and no interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| host_we | input | 1 | Host word write strobe |
| host_addr | input | AW | Pixel address within the frame, in row-major order |
| host_wdata | input | 32 | Pixel word: red in 23:16, green in 15:8, blue in 7:0 |
| host_frame_done | input | 1 | One-clock pulse after the last word of a frame |
| irq_o | output | 1 | One-clock request for the next frame |
| hsync_n_o | output | 1 | Horizontal sync, active low |
| vsync_n_o | output | 1 | Vertical sync, active low |
| red_o | output | 8 | Red channel to the DAC |
| green_o | output | 8 | Green channel to the DAC |
| blue_o | output | 8 | Blue channel to the DAC |

## Verification
The assertions check four properties on every clock. Colour is zero whenever either sync is active. The displayed store never changes except at a boundary where a frame is pending. Every interrupt is a single clock long and follows a change of store. A pending frame that is not re-armed is cleared by the swap. Whether each visible pixel shows the correct replicated source word, and whether the sync pulses fall at the correct positions, depends on the full raster. The bench therefore checks these by comparing every output cycle against a position computed from the cycle count, over several frames. These frames include swaps, a frame with no new data, and writes to the hidden store that must leave the image unchanged.

// File: rtl/vgadb_pkg.sv
package vgadb_pkg;

  localparam int WORD_W = 32;

  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } rgb_t;

  function automatic rgb_t word_to_rgb(input logic [WORD_W-1:0] w);
    rgb_t c;
    c.r = w[23:16];
    c.g = w[15:8];
    c.b = w[7:0];
    return c;
  endfunction

endpackage

// File: rtl/vgadb_raster.sv
module vgadb_raster #(
  parameter int VIS_W   = 640,
  parameter int H_FRONT = 16,
  parameter int H_SYNC  = 96,
  parameter int H_BACK  = 48,
  parameter int VIS_H   = 480,
  parameter int V_FRONT = 10,
  parameter int V_SYNC  = 2,
  parameter int V_BACK  = 33
) (
  input  logic clk,
  input  logic rst,
  output logic h_vis,
  output logic v_vis,
  output logic hsync_n,
  output logic vsync_n,
  output logic line_end,
  output logic frame_end,
  output logic vblank_start
);
  localparam int H_TOT = VIS_W + H_FRONT + H_SYNC + H_BACK;
  localparam int V_TOT = VIS_H + V_FRONT + V_SYNC + V_BACK;
  localparam int HW = $clog2(H_TOT);
  localparam int VW = $clog2(V_TOT);
  localparam logic [HW-1:0] H_LAST  = HW'(H_TOT - 1);
  localparam logic [HW-1:0] H_VISL  = HW'(VIS_W);
  localparam logic [HW-1:0] HS_BEG  = HW'(VIS_W + H_FRONT);
  localparam logic [HW-1:0] HS_END  = HW'(VIS_W + H_FRONT + H_SYNC);
  localparam logic [VW-1:0] V_LAST  = VW'(V_TOT - 1);
  localparam logic [VW-1:0] V_VISL  = VW'(VIS_H);
  localparam logic [VW-1:0] V_VLAST = VW'(VIS_H - 1);
  localparam logic [VW-1:0] VS_BEG  = VW'(VIS_H + V_FRONT);
  localparam logic [VW-1:0] VS_END  = VW'(VIS_H + V_FRONT + V_SYNC);

  logic [HW-1:0] hpos;
  logic [VW-1:0] vpos;

  always_ff @(posedge clk) begin
    if (rst) begin
      hpos <= '0;
      vpos <= '0;
    end else if (line_end) begin
      hpos <= '0;
      vpos <= (vpos == V_LAST) ? '0 : vpos + VW'(1);
    end else begin
      hpos <= hpos + HW'(1);
    end
  end

  always_comb begin
    line_end     = (hpos == H_LAST);
    frame_end    = line_end && (vpos == V_LAST);
    vblank_start = line_end && (vpos == V_VLAST);
    h_vis        = (hpos < H_VISL);
    v_vis        = (vpos < V_VISL);
    hsync_n      = !((hpos >= HS_BEG) && (hpos < HS_END));
    vsync_n      = !((vpos >= VS_BEG) && (vpos < VS_END));
  end

endmodule

// File: rtl/vgadb_scaler.sv
module vgadb_scaler #(
  parameter int SRC_W = 64,
  parameter int SRC_H = 48,
  parameter int REP   = 10,
  parameter int AW    = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          h_vis,
  input  logic          v_vis,
  input  logic          line_end,
  input  logic          frame_end,
  output logic [AW-1:0] rd_addr
);
  localparam int SUBW = (REP > 1) ? $clog2(REP) : 1;
  localparam int CW   = (SRC_W > 1) ? $clog2(SRC_W + 1) : 1;
  localparam int RW   = (SRC_H > 1) ? $clog2(SRC_H + 1) : 1;
  localparam logic [SUBW-1:0] SUB_LAST = SUBW'(REP - 1);

  logic [SUBW-1:0] hsub, vsub;
  logic [CW-1:0]   col;
  logic [RW-1:0]   row;

  always_ff @(posedge clk) begin
    if (rst || line_end) begin
      hsub <= '0;
      col  <= '0;
    end else if (h_vis) begin
      if (hsub == SUB_LAST) begin
        hsub <= '0;
        col  <= col + CW'(1);
      end else begin
        hsub <= hsub + SUBW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || frame_end) begin
      vsub <= '0;
      row  <= '0;
    end else if (line_end && v_vis) begin
      if (vsub == SUB_LAST) begin
        vsub <= '0;
        row  <= row + RW'(1);
      end else begin
        vsub <= vsub + SUBW'(1);
      end
    end
  end

  assign rd_addr = AW'(row) * AW'(SRC_W) + AW'(col);

endmodule

// File: rtl/vgadb_pingpong_ram.sv
module vgadb_pingpong_ram #(
  parameter int DEPTH = 3072,
  parameter int AW    = 12,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic          wr_bank,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_bank,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic rd_bank_q;
  logic wr_ok;

  assign wr_ok = wr_en && (32'(wr_addr) < DEPTH);

  for (genvar b = 0; b < 2; b++) begin : bank_g
    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (wr_ok && (wr_bank == 1'(b))) mem[wr_addr] <= wr_data;
      q <= mem[rd_addr];
    end
  end

  always_ff @(posedge clk) rd_bank_q <= rd_bank;

  assign rd_data = rd_bank_q ? bank_g[1].q : bank_g[0].q;

endmodule

// File: rtl/vgadb_swap_ctrl.sv
module vgadb_swap_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic vblank_start,
  input  logic frame_done,
  output logic disp_bank,
  output logic pending,
  output logic irq
);
  logic swap;

  assign swap = vblank_start && pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      disp_bank <= 1'b0;
      pending   <= 1'b0;
      irq       <= 1'b0;
    end else begin
      irq     <= swap;
      pending <= (pending && !swap) || frame_done;
      if (swap) disp_bank <= !disp_bank;
    end
  end

endmodule

// File: rtl/vga_dbuf_ctrl.sv
module vga_dbuf_ctrl #(
  parameter int SRC_W   = 64,
  parameter int SRC_H   = 48,
  parameter int REP     = 10,
  parameter int H_FRONT = 16,
  parameter int H_SYNC  = 96,
  parameter int H_BACK  = 48,
  parameter int V_FRONT = 10,
  parameter int V_SYNC  = 2,
  parameter int V_BACK  = 33,
  parameter int NPIX    = SRC_W * SRC_H,
  parameter int AW      = $clog2(NPIX)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [31:0]   host_wdata,
  input  logic          host_frame_done,
  output logic          irq_o,
  output logic          hsync_n_o,
  output logic          vsync_n_o,
  output logic [7:0]    red_o,
  output logic [7:0]    green_o,
  output logic [7:0]    blue_o
);
  import vgadb_pkg::*;

  localparam int VIS_W = SRC_W * REP;
  localparam int VIS_H = SRC_H * REP;

  logic h_vis, v_vis, hs_n, vs_n, line_end, frame_end, vblank_start;
  logic disp_bank, pending;
  logic [AW-1:0] rd_addr;
  logic [WORD_W-1:0] rd_word;
  logic act_d, hs_d, vs_d;
  rgb_t pix;

  vgadb_raster #(
    .VIS_W(VIS_W), .H_FRONT(H_FRONT), .H_SYNC(H_SYNC), .H_BACK(H_BACK),
    .VIS_H(VIS_H), .V_FRONT(V_FRONT), .V_SYNC(V_SYNC), .V_BACK(V_BACK)
  ) raster_i (
    .clk(clk), .rst(rst), .h_vis(h_vis), .v_vis(v_vis),
    .hsync_n(hs_n), .vsync_n(vs_n), .line_end(line_end),
    .frame_end(frame_end), .vblank_start(vblank_start)
  );

  vgadb_scaler #(
    .SRC_W(SRC_W), .SRC_H(SRC_H), .REP(REP), .AW(AW)
  ) scaler_i (
    .clk(clk), .rst(rst), .h_vis(h_vis), .v_vis(v_vis),
    .line_end(line_end), .frame_end(frame_end), .rd_addr(rd_addr)
  );

  vgadb_pingpong_ram #(
    .DEPTH(NPIX), .AW(AW), .DW(WORD_W)
  ) ram_i (
    .clk(clk), .wr_en(host_we), .wr_bank(!disp_bank),
    .wr_addr(host_addr), .wr_data(host_wdata),
    .rd_bank(disp_bank), .rd_addr(rd_addr), .rd_data(rd_word)
  );

  vgadb_swap_ctrl swap_i (
    .clk(clk), .rst(rst), .vblank_start(vblank_start),
    .frame_done(host_frame_done), .disp_bank(disp_bank),
    .pending(pending), .irq(irq_o)
  );

  assign pix = word_to_rgb(rd_word);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_d     <= 1'b0;
      hs_d      <= 1'b1;
      vs_d      <= 1'b1;
      hsync_n_o <= 1'b1;
      vsync_n_o <= 1'b1;
      red_o     <= '0;
      green_o   <= '0;
      blue_o    <= '0;
    end else begin
      act_d     <= h_vis && v_vis;
      hs_d      <= hs_n;
      vs_d      <= vs_n;
      hsync_n_o <= hs_d;
      vsync_n_o <= vs_d;
      red_o     <= act_d ? pix.r : '0;
      green_o   <= act_d ? pix.g : '0;
      blue_o    <= act_d ? pix.b : '0;
    end
  end

endmodule

// File: rtl/vgadb_chk.sv
module vgadb_chk (
  input logic       clk,
  input logic       rst,
  input logic       irq_o,
  input logic       hsync_n_o,
  input logic       vsync_n_o,
  input logic [7:0] red_o,
  input logic [7:0] green_o,
  input logic [7:0] blue_o,
  input logic       disp_bank,
  input logic       pending,
  input logic       vblank_start,
  input logic       host_frame_done
);
  // R4
  blank_in_hsync_chk: assert property (@(posedge clk) disable iff (rst)
    !hsync_n_o |-> ({red_o, green_o, blue_o} == 24'h0));

  // R4
  blank_in_vsync_chk: assert property (@(posedge clk) disable iff (rst)
    !vsync_n_o |-> ({red_o, green_o, blue_o} == 24'h0));

  // R8
  swap_only_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    !(vblank_start && pending) |=> $stable(disp_bank));

  // R8
  pending_consumed_chk: assert property (@(posedge clk) disable iff (rst)
    (vblank_start && pending && !host_frame_done) |=> !pending);

  // R9
  irq_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);

  // R9
  irq_follows_swap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> (disp_bank != $past(disp_bank)));
endmodule

bind vga_dbuf_ctrl vgadb_chk chk_i (
  .clk(clk), .rst(rst), .irq_o(irq_o),
  .hsync_n_o(hsync_n_o), .vsync_n_o(vsync_n_o),
  .red_o(red_o), .green_o(green_o), .blue_o(blue_o),
  .disp_bank(disp_bank), .pending(pending),
  .vblank_start(vblank_start), .host_frame_done(host_frame_done)
);

// File: tb/vga_dbuf_ctrl_tb_top.sv
module vga_dbuf_ctrl_tb_top;
  localparam int CLK_P = 10;
  localparam int SW = 4, SH = 3, REP = 2;
  localparam int HF = 2, HS = 3, HB = 2;
  localparam int VF = 1, VS = 2, VB = 2;
  localparam int NP = SW * SH;
  localparam int AW = $clog2(NP);
  localparam int HV = SW * REP, VV = SH * REP;
  localparam int HT = HV + HF + HS + HB, VT = VV + VF + VS + VB;
  localparam int FT = HT * VT;
  localparam int BND = VV * HT - 1;

  logic clk = 1'b0, rst = 1'b1;
  logic host_we = 1'b0, host_frame_done = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic irq_o, hsync_n_o, vsync_n_o;
  logic [7:0] red_o, green_o, blue_o;

  int n_chk = 0, n_fail = 0;
  int m = 0;
  int swap_at = -10;
  int pend_id = -1;
  int shown [64];
  bit mdl_ready = 0;
  int irq_seen = 0;
  bit done_flag = 0;

  vga_dbuf_ctrl #(
    .SRC_W(SW), .SRC_H(SH), .REP(REP),
    .H_FRONT(HF), .H_SYNC(HS), .H_BACK(HB),
    .V_FRONT(VF), .V_SYNC(VS), .V_BACK(VB)
  ) dut_i (
    .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_frame_done(host_frame_done),
    .irq_o(irq_o), .hsync_n_o(hsync_n_o), .vsync_n_o(vsync_n_o),
    .red_o(red_o), .green_o(green_o), .blue_o(blue_o)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [31:0] pix(input int id, input int a);
    return {8'(8'hA5 ^ a), 8'(id * 17 + a), 8'(a * 3 + id), 8'(255 - a - id * 5)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at m=%0d", req, act, exp, m);
    end
  endtask

  // Reference model of the raster position and the swap rule, from the requirements
  always @(posedge clk) begin
    if (rst) begin
      m = 0;
      mdl_ready = 0;
    end else begin
      if ((m % FT) == BND) begin
        int fr;
        fr = m / FT;
        if (fr + 1 < 64) begin
          if (mdl_ready) begin
            shown[fr + 1] = pend_id;
            swap_at = m + 1;
            mdl_ready = 0;
          end else begin
            shown[fr + 1] = shown[fr];
          end
        end
      end
      if (host_frame_done) mdl_ready = 1;
      m = m + 1;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      int p, h, v, f, id;
      bit ehs, evs, act;
      logic [23:0] exp_rgb;
      p = m - 2;
      if (irq_o) irq_seen++;
      chk(irq_o == (m == swap_at), "R9 irq timing", 32'(irq_o), 32'(m == swap_at));
      if (p < 0) begin
        chk(hsync_n_o && vsync_n_o && {red_o, green_o, blue_o} == 24'h0, "R1 post-reset outputs",
            {6'h0, hsync_n_o, vsync_n_o, red_o, green_o, blue_o}, 32'h0300_0000);
      end else begin
        h = p % HT;
        v = (p / HT) % VT;
        f = p / FT;
        ehs = !(h >= HV + HF && h < HV + HF + HS);
        evs = !(v >= VV + VF && v < VV + VF + VS);
        act = (h < HV) && (v < VV);
        chk(hsync_n_o == ehs, "R2/R6 hsync", 32'(hsync_n_o), 32'(ehs));
        chk(vsync_n_o == evs, "R3/R6 vsync", 32'(vsync_n_o), 32'(evs));
        if (!act) begin
          chk({red_o, green_o, blue_o} == 24'h0, "R4 blanking colour",
              32'({red_o, green_o, blue_o}), 32'h0);
        end else begin
          id = (f < 64) ? shown[f] : -1;
          if (id >= 0) begin
            exp_rgb = pix(id, (v / REP) * SW + h / REP)[23:0];
            // R5 replication and channel mapping; R7/R10 image source
            chk({red_o, green_o, blue_o} == exp_rgb, "R5/R7/R10 pixel",
                32'({red_o, green_o, blue_o}), 32'(exp_rgb));
          end
        end
      end
    end
  end

  task automatic write_frame(input int id, input bit with_done);
    for (int a = 0; a < NP; a++) begin
      @(negedge clk);
      host_we = 1'b1;
      host_addr = AW'(a);
      host_wdata = pix(id, a);
    end
    @(negedge clk);
    host_we = 1'b0;
    if (with_done) begin
      pend_id = id;
      host_frame_done = 1'b1;
      @(negedge clk);
      host_frame_done = 1'b0;
    end
  endtask

  task automatic wait_irq();
    @(negedge clk);
    while (!irq_o) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) shown[i] = -1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(hsync_n_o && vsync_n_o && !irq_o && {red_o, green_o, blue_o} == 24'h0,
        "R1 reset state", {7'h0, irq_o, red_o, green_o, blue_o}, 32'h0);
    rst = 1'b0;
    // R7/R8: first frame into the hidden store, then swap
    write_frame(1, 1'b1);
    wait_irq();
    write_frame(2, 1'b1);
    wait_irq();
    // R7: writes to the hidden store without completion must not alter the image
    write_frame(7, 1'b0);
    // R10: several frames with nothing ready
    repeat (3 * FT) @(negedge clk);
    write_frame(3, 1'b1);
    wait_irq();
    repeat (FT + 5) @(negedge clk);
    // R9/R10: exactly one interrupt per completed frame
    chk(irq_seen == 3, "R9/R10 interrupt count", 32'(irq_seen), 32'd3);
    finish_run();
  end

  initial begin
    #(CLK_P * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

endmodule